// File: doc/BRIEF.md
# Synchronous Shift Register Serial Port

This block is a half-duplex, 8-bit synchronous serial channel that a host drives through a small register interface. One pin carries serial data in either direction, and a second pin supplies the shift clock to an external partner. The host starts a transmit by writing a byte to the data buffer register. A receive starts on its own once reception is enabled and the receive-done flag is clear. Both directions move exactly eight bits, least significant bit first.

The shift clock runs at the core clock divided by a parameter (12 by default). It idles high. In each bit period the clock is low for the first half and high for the second half. Outgoing data changes when the clock falls. Incoming data is sampled when the clock rises. During a receive the block stops driving the data pin, and its output-enable goes low.

The register map has two addresses. Address 0 is the control register: bit 0 is transmit-done, bit 1 is receive-done, bit 2 is receive-enable, and bits 4:3 select the mode, where 00 means shift-register mode. Bits 7:5 read as zero. Address 1 is the data buffer. Reads are combinational from `addr_i`. Writes take one cycle with `wr_en_i` high.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the control register reads 0x00, the data buffer reads 0x00, `sclk_o` is high, `sdata_oe_o` is low and `sdata_o` is high.
- R2: Transfers start only when the mode field (control bits 4:3) is 00. With any other mode, a write to the data buffer stores the byte but produces no shift clock, and no receive starts.
- R3: A data-buffer write while idle, in mode 00, sends the byte on `sdata_o`, least significant bit first, with `sdata_oe_o` high. Each bit changes only when `sclk_o` falls, and exactly 8 rising edges are produced.
- R4: While a transfer is active, each bit lasts DIV core cycles: `sclk_o` is low for the first DIV/2 cycles and high for the rest. Bit 0's period begins in the cycle after the starting edge. `sclk_o` is high whenever the block is idle.
- R5: Transmit-done (control bit 0) is set by the clock edge 8*DIV cycles after the edge that accepted the data write. `sdata_oe_o` drops at that same edge.
- R6: Receive-enable (bit 2) set with receive-done (bit 1) clear starts a receive in the next cycle. `sdata_oe_o` stays low, and `sdata_i` is sampled at each rising edge of `sclk_o`, least significant bit first. 8*DIV cycles later the byte is in the data buffer and receive-done is set.
- R7: No receive starts while receive-done is set or receive-enable is 0, and `sclk_o` stays high.
- R8: Each flag stays set until a control write puts 0 in its bit position. Writing 1 to a flag bit leaves it unchanged.
- R9: A data-buffer write that arrives while a transfer is in progress is ignored. Neither the buffer nor the byte being shifted changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 data buffer |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| sdata_i | input | 1 | Serial data pin, input side |
| sdata_o | output | 1 | Serial data pin, output side |
| sdata_oe_o | output | 1 | Drive enable for the serial data pin |
| sclk_o | output | 1 | Shift clock output |

## Verification
The assertions assume that the external partner changes `sdata_i` only right after a falling shift-clock edge, so the value is settled at the next rising edge. They also assume that host writes are single-cycle strobes presented between clock edges. The bench's partner model updates its data bit on every falling edge of `sclk_o` and keeps an index modulo 8. Because every transfer produces exactly eight falling edges, the index lines up with bit 0 at the start of each receive. All bus writes are driven just after a rising core-clock edge and released after the next one.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
  localparam logic [1:0] MODE_SHIFT = 2'b00;

  typedef struct packed {
    logic [2:0] rsvd;
    logic [1:0] mode;
    logic       rx_en;
    logic       rx_done;
    logic       tx_done;
  } ctrl_t;
endpackage

// File: rtl/ssp_timing.sv
module ssp_timing #(
  parameter int unsigned DIV  = 12,
  parameter int unsigned BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic sample_o,
  output logic bit_end_o,
  output logic last_o,
  output logic sclk_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PW   = $clog2(DIV);
  localparam int unsigned BW   = $clog2(BITS);

  logic          busy_q;
  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;

  assign busy_o    = busy_q;
  assign bit_end_o = busy_q && (phase_q == PW'(DIV - 1));
  assign last_o    = bit_end_o && (bit_q == BW'(BITS - 1));
  assign sample_o  = busy_q && (phase_q == PW'(HALF - 1));
  assign sclk_o    = busy_q ? (phase_q >= PW'(HALF)) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= '0;
        bit_q   <= '0;
      end
    end else if (bit_end_o) begin
      phase_q <= '0;
      if (last_o) busy_q <= 1'b0;
      else        bit_q  <= bit_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // R4: the first shift-clock phase after a start is low
  a_r4_first_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> !sclk_o);
  // R5: the transfer ends on the last bit boundary
  a_r5_ends_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o && sclk_o);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tx_shift_i,
  input  logic         rx_sample_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  assign q_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_q <= '0;
    else if (load_i)      q_q <= load_val_i;
    else if (rx_sample_i) q_q <= {ser_i, q_q[W-1:1]};
    else if (tx_shift_i)  q_q <= {1'b1, q_q[W-1:1]};
  end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              start_o,
  output logic              start_rx_o,
  output logic              rx_dir_o,
  output logic              rx_en_o,
  output logic              rx_done_o
);
  ctrl_t             ctrl_q, wr_ctrl_val;
  logic [DATA_W-1:0] buf_q;
  logic              dir_q;
  logic              wr_ctrl, wr_data, shift_mode, start_tx;

  assign wr_ctrl     = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_data     = wr_en_i && (addr_i == ADDR_DATA);
  assign wr_ctrl_val = ctrl_t'(wdata_i);
  assign shift_mode  = (ctrl_q.mode == MODE_SHIFT);
  assign start_tx    = wr_data && !busy_i && shift_mode;
  assign start_rx_o  = !busy_i && shift_mode && ctrl_q.rx_en && !ctrl_q.rx_done && !start_tx;
  assign start_o     = start_tx || start_rx_o;
  assign rx_dir_o    = dir_q;
  assign rx_en_o     = ctrl_q.rx_en;
  assign rx_done_o   = ctrl_q.rx_done;
  assign rdata_o     = (addr_i == ADDR_CTRL) ? ctrl_q : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.mode    <= wr_ctrl_val.mode;
        ctrl_q.rx_en   <= wr_ctrl_val.rx_en;
        ctrl_q.tx_done <= ctrl_q.tx_done & wr_ctrl_val.tx_done;
        ctrl_q.rx_done <= ctrl_q.rx_done & wr_ctrl_val.rx_done;
      end
      if (wr_data && !busy_i) buf_q <= wdata_i;
      if (start_o) dir_q <= start_rx_o;
      // completion has priority over a same-cycle clear
      if (last_i) begin
        if (dir_q) begin
          buf_q          <= rx_word_i;
          ctrl_q.rx_done <= 1'b1;
        end else begin
          ctrl_q.tx_done <= 1'b1;
        end
      end
    end
  end

  a_r8_tx_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.tx_done && !wr_ctrl |=> ctrl_q.tx_done);
  a_r8_rx_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.rx_done && !wr_ctrl |=> ctrl_q.rx_done);
  a_r9_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && busy_i && !last_i |=> $stable(buf_q));
  a_r5_tx_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i && !dir_q |=> ctrl_q.tx_done);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int unsigned DIV = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       sdata_i,
  output logic       sdata_o,
  output logic       sdata_oe_o,
  output logic       sclk_o
);
  import ssp_pkg::*;

  logic              start_w, start_rx_w, rx_dir_w, rx_en_w, rx_done_w;
  logic              busy_w, sample_w, bit_end_w, last_w;
  logic [DATA_W-1:0] shreg_w;

  ssp_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .busy_i     (busy_w),
    .last_i     (last_w),
    .rx_word_i  (shreg_w),
    .start_o    (start_w),
    .start_rx_o (start_rx_w),
    .rx_dir_o   (rx_dir_w),
    .rx_en_o    (rx_en_w),
    .rx_done_o  (rx_done_w)
  );

  ssp_timing #(.DIV(DIV), .BITS(DATA_W)) i_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .busy_o    (busy_w),
    .sample_o  (sample_w),
    .bit_end_o (bit_end_w),
    .last_o    (last_w),
    .sclk_o    (sclk_o)
  );

  ssp_shifter #(.W(DATA_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_w && !busy_w && !start_rx_w),
    .load_val_i  (wdata_i),
    .tx_shift_i  (bit_end_w && !rx_dir_w),
    .rx_sample_i (sample_w && rx_dir_w),
    .ser_i       (sdata_i),
    .q_o         (shreg_w)
  );

  assign sdata_oe_o = busy_w && !rx_dir_w;
  assign sdata_o    = sdata_oe_o ? shreg_w[0] : 1'b1;

  // R3: outgoing data moves only with a falling shift clock
  a_r3_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o && $past(sdata_oe_o) && !$stable(sdata_o) |-> $fell(sclk_o));
  // R7: a receive begins only when enabled with the flag clear
  a_r7_rx_start_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_w) && rx_dir_w |-> $past(rx_en_w && !rx_done_w));
  // R6: the pin is never driven during a receive
  a_r6_released_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w && rx_dir_w |-> !sdata_oe_o && sdata_o);
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 12;
  localparam int XFER = 8 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sdata_i = 1'b1;
  logic       sdata_o, sdata_oe, sclk;

  int n_chk = 0;
  int n_fail = 0;

  sync_shift_port #(.DIV(DIV)) i_sync_shift_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe),
    .sclk_o(sclk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // partner device: presents the next bit on each falling shift clock
  logic [7:0] slave_byte = '0;
  logic [2:0] slave_idx = '0;
  always @(negedge sclk) begin
    sdata_i   <= slave_byte[slave_idx];
    slave_idx <= slave_idx + 3'd1;
  end

  // monitor: counts rising edges, captures driven bits
  int         rise_n = 0;
  logic [7:0] cap = '0;
  always @(posedge sclk) begin
    rise_n <= rise_n + 1;
    if (sdata_oe) cap <= {sdata_o, cap[7:1]};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    logic [7:0] r;
    int base;
    int errs;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(1'b0, r); chk(r == 8'h00, "R1 ctrl", r, 0);
    rd(1'b1, r); chk(r == 8'h00, "R1 buffer", r, 0);
    chk(sclk && !sdata_oe && sdata_o, "R1 pins", {sclk, sdata_oe, sdata_o}, 3'b101);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 R4 R5: exhaustive transmit sweep, cycle-exact
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      addr = 1'b0;
      errs = 0;
      for (int c = 0; c < XFER; c++) begin
        @(negedge clk);
        if (sclk !== ((c % DIV) >= DIV / 2)) errs++;
        if (sdata_oe !== 1'b1) errs++;
        if (sdata_o !== v[c / DIV]) errs++;
        if (c == XFER - 1 && rdata[0] !== 1'b0) errs++;
      end
      chk(errs == 0, "R3/R4 tx waveform", errs, 0);
      @(negedge clk);
      chk(rdata[0] && !sdata_oe && sclk, "R5 tx_done timing", {rdata[0], sdata_oe, sclk}, 3'b101);
      wr(1'b0, 8'h00);
    end

    // R6: exhaustive receive sweep
    for (int v = 0; v < 256; v++) begin
      slave_byte = 8'(v);
      wr(1'b0, 8'h04);
      addr = 1'b0;
      errs = 0;
      for (int k = 1; k <= XFER + 2; k++) begin
        @(negedge clk);
        if (sdata_oe !== 1'b0) errs++;
        if (k == XFER + 1 && rdata[1] !== 1'b0) errs++;
        if (k == XFER + 2 && rdata[1] !== 1'b1) errs++;
      end
      chk(errs == 0, "R6 rx pin/flag timing", errs, 0);
      rd(1'b1, r);
      chk(r == 8'(v), "R6 rx byte", r, v);
      if (v != 255) wr(1'b0, 8'h00);
    end

    // R7: flag still set, rx_en still 1: nothing starts
    base = rise_n;
    repeat (3 * DIV) @(negedge clk);
    chk(rise_n == base && sclk, "R7 no rx while rx_done", rise_n - base, 0);
    // R8 + R6: clear rx_done with bit1=0, rx restarts
    slave_byte = 8'hC3;
    wr(1'b0, 8'h04);
    repeat (XFER + 3) @(negedge clk);
    rd(1'b1, r);
    chk(r == 8'hC3, "R6 rx after flag clear", r, 8'hC3);
    chk(rise_n - base == 8, "R6 eight rx clocks", rise_n - base, 8);
    // R7: rx_en 0
    wr(1'b0, 8'h00);
    base = rise_n;
    repeat (3 * DIV) @(negedge clk);
    chk(rise_n == base, "R7 no rx when disabled", rise_n - base, 0);

    // R8: flag persistence and clear rules
    wr(1'b1, 8'h81);
    repeat (XFER + 50) @(negedge clk);
    rd(1'b0, r); chk(r == 8'h01, "R8 tx_done persists", r, 1);
    wr(1'b0, 8'h03);
    rd(1'b0, r); chk(r == 8'h01, "R8 write 1 keeps flag", r, 1);
    wr(1'b0, 8'h00);
    rd(1'b0, r); chk(r == 8'h00, "R8 write 0 clears flag", r, 0);

    // R9: write during transfer ignored
    wr(1'b1, 8'hA5);
    repeat (2 * DIV) @(negedge clk);
    wr(1'b1, 8'h3C);
    repeat (XFER) @(negedge clk);
    chk(cap == 8'hA5, "R9 shifted byte unchanged", cap, 8'hA5);
    rd(1'b1, r); chk(r == 8'hA5, "R9 buffer unchanged", r, 8'hA5);
    wr(1'b0, 8'h00);

    // R2: non-shift modes block transfers
    wr(1'b0, 8'h08);
    base = rise_n;
    wr(1'b1, 8'h5A);
    repeat (3 * DIV) @(negedge clk);
    chk(rise_n == base, "R2 no tx in mode 01", rise_n - base, 0);
    rd(1'b0, r); chk(r == 8'h08, "R2 ctrl in mode 01", r, 8'h08);
    rd(1'b1, r); chk(r == 8'h5A, "R2 buffer stored", r, 8'h5A);
    wr(1'b0, 8'h14);
    repeat (3 * DIV) @(negedge clk);
    chk(rise_n == base && !sdata_oe, "R2 no rx in mode 10", rise_n - base, 0);
    wr(1'b0, 8'h00);

    summary();
  end
endmodule